// File: doc/BRIEF.md
# Flash Embedded-Operation Timer and Status Generator

This block tracks the progress of the timed internal operations of a parallel NOR flash model: byte or word programming, sector erase and whole-chip erase. A command sequencer elsewhere decodes the bus write cycles and sends this block one-cycle request strobes. The block answers with a busy flag, a suspended flag, the polled status byte, and one-cycle pulses for completion, abort and rejection. The storage array itself is handled elsewhere.

Sector erase starts with an accumulation window. While the window is open, further sector-erase requests are added to the pending count and restart the window. When the window closes, the erase runs for a time proportional to the number of sectors. An erase can be suspended, either inside the window or while it is running. The remaining time is saved, and a resume continues from it. All durations are counted in ticks. A tick is a fixed number of clock cycles, so simulation can scale the times down.

Top module: `erase_status_engine`

## Requirements
- R1: After reset, statusByte is 0x00, busy and suspended are 0, and all three pulses are 0. Status bits are DQ7 = bit 7, DQ6 = bit 6, DQ3 = bit 3 and DQ2 = bit 2. All other bits always read 0.
- R2: When idle, programReq sets DQ7 to the inverse of progMsb and raises busy. A timed operation of N ticks ends at the clock edge N*TICK_DIV cycles after the edge that started it, because the prescaler restarts on every load. A program lasts PROG_TICKS ticks.
- R3: A statusRd strobe toggles DQ6 during a program, and toggles both DQ6 and DQ2 during the window, a sector erase or a chip erase. It changes nothing when idle. The toggled byte is visible from the cycle after the strobe.
- R4: Each sectorEraseReq, whether from idle or inside the window, clears DQ7, adds one to the pending count and restarts the window. The count saturates at MAX_SECTORS. The window lasts WINDOW_TICKS ticks, and DQ3 stays 0 while it is open.
- R5: When the window ends, DQ3 is set and the erase runs for count * 2^BLK_EXP ticks.
- R6: chipEraseReq from idle clears DQ7 and runs for 2^CHIP_EXP ticks. Requests made during that time have no effect.
- R7: Any of programReq, chipEraseReq, resumeReq or otherWriteReq inside the window aborts the erase. The block pulses abortPulse, returns to idle and clears the count.
- R8: While the erase itself runs (DQ3 = 1), every request except suspendReq is ignored.
- R9: suspendReq inside the window saves the full erase time (count * 2^BLK_EXP). During the running erase it saves the remaining ticks, which is never less than 1. In both cases the timer stops, DQ3 clears, busy drops and suspended rises.
- R10: While suspended, statusRd with hitErasing = 1 toggles DQ2 only. With hitErasing = 0 it changes nothing.
- R11: While suspended, a program with hitErasing = 1 and every erase request give rejectPulse and change nothing else. A program with hitErasing = 0 sets DQ7 to the inverse of progMsb at once, with no busy period.
- R12: resumeReq while suspended clears DQ7, sets DQ3, clears the saved time and runs the erase for the saved ticks.
- R13: Completion of any operation pulses donePulse in the following cycle, toggles DQ7, clears DQ3 and the count, and returns to idle. A request that arrives on the edge where the timer would expire takes priority over the expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| programReq | input | 1 | Program start strobe |
| progMsb | input | 1 | Bit 7 of the data being programmed |
| sectorEraseReq | input | 1 | Sector-erase command strobe |
| chipEraseReq | input | 1 | Chip-erase command strobe |
| suspendReq | input | 1 | Erase-suspend strobe |
| resumeReq | input | 1 | Erase-resume strobe |
| otherWriteReq | input | 1 | Any other bus write |
| statusRd | input | 1 | Status-read strobe |
| hitErasing | input | 1 | Access address lies in an erasing sector |
| busy | output | 1 | Timed operation in progress |
| suspended | output | 1 | Erase suspended |
| statusByte | output | 8 | Polled status byte |
| donePulse | output | 1 | Operation completed |
| abortPulse | output | 1 | Erase aborted inside the window |
| rejectPulse | output | 1 | Request refused while suspended |

## Verification
Every result of a strobe, whether a start, a toggle, an abort, a rejection, a suspend or a resume, appears one cycle after the edge that samples it. A completion changes state on the edge N*TICK_DIV cycles after the load, and its pulse is visible in the cycle after that edge. The bench keeps a behavioural model that updates on each rising edge from the same inputs. It compares every output with the model at the following falling edge, so each result is checked in exactly the cycle it becomes due. Strobes that must coincide with a timer expiry are timed from the model's own remaining-tick count.

// File: rtl/esg_pkg.sv
package esg_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PROG,
    OP_WINDOW,
    OP_ERASE,
    OP_CHIP,
    OP_SUSP
  } opState_t;

  typedef enum logic [2:0] {
    LD_WINDOW,
    LD_SECTORS,
    LD_CHIP,
    LD_PROG,
    LD_SAVED
  } loadSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    loadSel_t loadSel;
    logic     stop;
    logic     cntInc;
    logic     cntClr;
    logic     saveFull;
    logic     saveRem;
    logic     savedClr;
    logic     dq7Clr;
    logic     dq7Prog;
    logic     dq7Tog;
    logic     dq3Set;
    logic     dq3Clr;
    logic     tog6;
    logic     tog2;
  } dpCtl_t;

endpackage

// File: rtl/esg_datapath.sv
module esg_datapath
  import esg_pkg::*;
#(
  parameter int TICK_DIV     = 200,
  parameter int WINDOW_TICKS = 50,
  parameter int BLK_EXP      = 19,
  parameter int CHIP_EXP     = 22,
  parameter int PROG_TICKS   = 8,
  parameter int MAX_SECTORS  = 64,
  parameter int TIME_W       = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  dpCtl_t     ctl,
  input  logic       progMsb,
  output logic       expire,
  output logic [7:0] statusByte
);

  localparam int CNT_W = $clog2(MAX_SECTORS + 1);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_SECTORS);

  logic [CNT_W-1:0]  sectorCnt;
  logic [TIME_W-1:0] remTicks;
  logic [TIME_W-1:0] savedTicks;
  logic [TIME_W-1:0] loadVal;
  logic [TIME_W-1:0] sectorTime;
  logic [DIV_W-1:0]  preCnt;
  logic              running;
  logic              tickNow;
  logic              dq7, dq6, dq3, dq2;

  assign sectorTime = TIME_W'(sectorCnt) << BLK_EXP;
  assign tickNow    = running && (preCnt == DIV_W'(TICK_DIV - 1));
  assign expire     = tickNow && (remTicks == TIME_W'(1));

  always_comb begin
    case (ctl.loadSel)
      LD_WINDOW:  loadVal = TIME_W'(WINDOW_TICKS);
      LD_SECTORS: loadVal = sectorTime;
      LD_CHIP:    loadVal = TIME_W'(1) << CHIP_EXP;
      LD_PROG:    loadVal = TIME_W'(PROG_TICKS);
      LD_SAVED:   loadVal = savedTicks;
      default:    loadVal = TIME_W'(1);
    endcase
  end

  // tick timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      remTicks <= '0;
      preCnt   <= '0;
    end else if (ctl.load) begin
      running  <= 1'b1;
      remTicks <= loadVal;
      preCnt   <= '0;
    end else if (ctl.stop || expire) begin
      running  <= 1'b0;
    end else if (tickNow) begin
      preCnt   <= '0;
      remTicks <= remTicks - 1'b1;
    end else if (running) begin
      preCnt   <= preCnt + 1'b1;
    end
  end

  // pending sector count, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sectorCnt <= '0;
    end else if (ctl.cntClr) begin
      sectorCnt <= '0;
    end else if (ctl.cntInc && (sectorCnt != CNT_MAX)) begin
      sectorCnt <= sectorCnt + 1'b1;
    end
  end

  // time saved across a suspend
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      savedTicks <= '0;
    end else if (ctl.saveFull) begin
      savedTicks <= sectorTime;
    end else if (ctl.saveRem) begin
      savedTicks <= remTicks;
    end else if (ctl.savedClr) begin
      savedTicks <= '0;
    end
  end

  // status bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq7 <= 1'b0;
      dq6 <= 1'b0;
      dq3 <= 1'b0;
      dq2 <= 1'b0;
    end else begin
      if (ctl.dq7Clr)       dq7 <= 1'b0;
      else if (ctl.dq7Prog) dq7 <= ~progMsb;
      else if (ctl.dq7Tog)  dq7 <= ~dq7;
      if (ctl.tog6)         dq6 <= ~dq6;
      if (ctl.dq3Set)       dq3 <= 1'b1;
      else if (ctl.dq3Clr)  dq3 <= 1'b0;
      if (ctl.tog2)         dq2 <= ~dq2;
    end
  end

  assign statusByte = {dq7, dq6, 2'b00, dq3, dq2, 2'b00};

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sectorCnt <= CNT_MAX)
    else $error("pending sector count above its limit");

  a_r9_saved_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.saveRem || ctl.saveFull) |=> (savedTicks != '0))
    else $error("suspend saved zero remaining time");

endmodule

// File: rtl/esg_ctrl.sv
module esg_ctrl
  import esg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   programReq,
  input  logic   sectorEraseReq,
  input  logic   chipEraseReq,
  input  logic   suspendReq,
  input  logic   resumeReq,
  input  logic   otherWriteReq,
  input  logic   statusRd,
  input  logic   hitErasing,
  input  logic   expire,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   suspended,
  output logic   donePulse,
  output logic   abortPulse,
  output logic   rejectPulse
);

  opState_t state, stateNxt;
  logic     doneNxt, abortNxt, rejectNxt;

  always_comb begin
    ctl       = '0;
    stateNxt  = state;
    doneNxt   = 1'b0;
    abortNxt  = 1'b0;
    rejectNxt = 1'b0;

    case (state)
      OP_IDLE: begin
        if (programReq) begin
          stateNxt    = OP_PROG;
          ctl.load    = 1'b1;
          ctl.loadSel = LD_PROG;
          ctl.dq7Prog = 1'b1;
        end else if (sectorEraseReq) begin
          stateNxt    = OP_WINDOW;
          ctl.load    = 1'b1;
          ctl.loadSel = LD_WINDOW;
          ctl.cntInc  = 1'b1;
          ctl.dq7Clr  = 1'b1;
        end else if (chipEraseReq) begin
          stateNxt    = OP_CHIP;
          ctl.load    = 1'b1;
          ctl.loadSel = LD_CHIP;
          ctl.dq7Clr  = 1'b1;
        end
      end

      OP_WINDOW: begin
        if (sectorEraseReq) begin
          ctl.load    = 1'b1;
          ctl.loadSel = LD_WINDOW;
          ctl.cntInc  = 1'b1;
          ctl.dq7Clr  = 1'b1;
        end else if (suspendReq) begin
          stateNxt     = OP_SUSP;
          ctl.stop     = 1'b1;
          ctl.saveFull = 1'b1;
          ctl.dq3Clr   = 1'b1;
        end else if (programReq || chipEraseReq || resumeReq || otherWriteReq) begin
          stateNxt   = OP_IDLE;
          ctl.stop   = 1'b1;
          ctl.cntClr = 1'b1;
          abortNxt   = 1'b1;
        end else if (expire) begin
          stateNxt    = OP_ERASE;
          ctl.load    = 1'b1;
          ctl.loadSel = LD_SECTORS;
          ctl.dq3Set  = 1'b1;
        end
      end

      OP_ERASE: begin
        if (suspendReq) begin
          stateNxt    = OP_SUSP;
          ctl.stop    = 1'b1;
          ctl.saveRem = 1'b1;
          ctl.dq3Clr  = 1'b1;
        end else if (expire) begin
          stateNxt   = OP_IDLE;
          ctl.cntClr = 1'b1;
          ctl.dq7Tog = 1'b1;
          ctl.dq3Clr = 1'b1;
          doneNxt    = 1'b1;
        end
      end

      OP_PROG, OP_CHIP: begin
        if (expire) begin
          stateNxt   = OP_IDLE;
          ctl.cntClr = 1'b1;
          ctl.dq7Tog = 1'b1;
          ctl.dq3Clr = 1'b1;
          doneNxt    = 1'b1;
        end
      end

      OP_SUSP: begin
        if (resumeReq) begin
          stateNxt     = OP_ERASE;
          ctl.load     = 1'b1;
          ctl.loadSel  = LD_SAVED;
          ctl.savedClr = 1'b1;
          ctl.dq7Clr   = 1'b1;
          ctl.dq3Set   = 1'b1;
        end else if (programReq) begin
          if (hitErasing) rejectNxt   = 1'b1;
          else            ctl.dq7Prog = 1'b1;
        end else if (sectorEraseReq || chipEraseReq) begin
          rejectNxt = 1'b1;
        end
      end

      default: stateNxt = OP_IDLE;
    endcase

    if (statusRd) begin
      case (state)
        OP_PROG:                      ctl.tog6 = 1'b1;
        OP_WINDOW, OP_ERASE, OP_CHIP: begin
          ctl.tog6 = 1'b1;
          ctl.tog2 = 1'b1;
        end
        OP_SUSP:                      ctl.tog2 = hitErasing;
        default:                      ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= OP_IDLE;
      donePulse   <= 1'b0;
      abortPulse  <= 1'b0;
      rejectPulse <= 1'b0;
    end else begin
      state       <= stateNxt;
      donePulse   <= doneNxt;
      abortPulse  <= abortNxt;
      rejectPulse <= rejectNxt;
    end
  end

  assign busy      = (state == OP_PROG) || (state == OP_WINDOW) ||
                     (state == OP_ERASE) || (state == OP_CHIP);
  assign suspended = (state == OP_SUSP);

  a_r13_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    donePulse |-> (!busy && $past(busy)))
    else $error("completion pulse without a preceding busy period");

  a_r7_abort_from_window: assert property (@(posedge clk) disable iff (!rst_n)
    abortPulse |-> (!busy && !suspended))
    else $error("abort did not return to idle");

endmodule

// File: rtl/erase_status_engine.sv
module erase_status_engine
  import esg_pkg::*;
#(
  parameter int TICK_DIV     = 200,
  parameter int WINDOW_TICKS = 50,
  parameter int BLK_EXP      = 19,
  parameter int CHIP_EXP     = 22,
  parameter int PROG_TICKS   = 8,
  parameter int MAX_SECTORS  = 64,
  parameter int TIME_W       = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       programReq,
  input  logic       progMsb,
  input  logic       sectorEraseReq,
  input  logic       chipEraseReq,
  input  logic       suspendReq,
  input  logic       resumeReq,
  input  logic       otherWriteReq,
  input  logic       statusRd,
  input  logic       hitErasing,
  output logic       busy,
  output logic       suspended,
  output logic [7:0] statusByte,
  output logic       donePulse,
  output logic       abortPulse,
  output logic       rejectPulse
);

  dpCtl_t ctl;
  logic   expire;

  esg_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .programReq     (programReq),
    .sectorEraseReq (sectorEraseReq),
    .chipEraseReq   (chipEraseReq),
    .suspendReq     (suspendReq),
    .resumeReq      (resumeReq),
    .otherWriteReq  (otherWriteReq),
    .statusRd       (statusRd),
    .hitErasing     (hitErasing),
    .expire         (expire),
    .ctl            (ctl),
    .busy           (busy),
    .suspended      (suspended),
    .donePulse      (donePulse),
    .abortPulse     (abortPulse),
    .rejectPulse    (rejectPulse)
  );

  esg_datapath #(
    .TICK_DIV     (TICK_DIV),
    .WINDOW_TICKS (WINDOW_TICKS),
    .BLK_EXP      (BLK_EXP),
    .CHIP_EXP     (CHIP_EXP),
    .PROG_TICKS   (PROG_TICKS),
    .MAX_SECTORS  (MAX_SECTORS),
    .TIME_W       (TIME_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .progMsb    (progMsb),
    .expire     (expire),
    .statusByte (statusByte)
  );

  a_r2_program_start: assert property (@(posedge clk) disable iff (!rst_n)
    (programReq && !busy && !suspended) |=> (busy && (statusByte[7] == !$past(progMsb))))
    else $error("program start did not set busy and inverted msb");

  a_r9_suspend_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> (!busy && !statusByte[3]))
    else $error("suspend left busy or DQ3 set");

  a_r12_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && resumeReq) |=> (busy && statusByte[3] && !statusByte[7]))
    else $error("resume did not restart the erase");

endmodule

// File: tb/erase_status_engine_tb.sv
`timescale 1ns/1ps
module erase_status_engine_tb;

  localparam int TDIV  = 3;
  localparam int WIN   = 4;
  localparam int BEXP  = 2;
  localparam int CEXP  = 4;
  localparam int PTK   = 3;
  localparam int MAXS  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic programReq = 0, progMsb = 0, sectorEraseReq = 0, chipEraseReq = 0;
  logic suspendReq = 0, resumeReq = 0, otherWriteReq = 0, statusRd = 0, hitErasing = 0;
  logic busy, suspended, donePulse, abortPulse, rejectPulse;
  logic [7:0] statusByte;

  always #2.5 clk = ~clk;

  erase_status_engine #(
    .TICK_DIV(TDIV), .WINDOW_TICKS(WIN), .BLK_EXP(BEXP), .CHIP_EXP(CEXP),
    .PROG_TICKS(PTK), .MAX_SECTORS(MAXS), .TIME_W(16)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .programReq(programReq), .progMsb(progMsb),
    .sectorEraseReq(sectorEraseReq), .chipEraseReq(chipEraseReq),
    .suspendReq(suspendReq), .resumeReq(resumeReq), .otherWriteReq(otherWriteReq),
    .statusRd(statusRd), .hitErasing(hitErasing), .busy(busy), .suspended(suspended),
    .statusByte(statusByte), .donePulse(donePulse), .abortPulse(abortPulse),
    .rejectPulse(rejectPulse)
  );

  // ---------------- behavioural reference ----------------
  // modes: 0 idle, 1 program, 2 window, 3 erase, 4 chip, 5 suspended
  int m_mode, m_cnt, m_rem, m_pre, m_saved;
  bit m_run, m_d7, m_d6, m_d3, m_d2, m_done, m_abort, m_rej;

  function automatic void startTimer(int n);
    m_rem = n; m_pre = 0; m_run = 1;
  endfunction

  function automatic void finishOp();
    m_mode = 0; m_cnt = 0; m_d7 = !m_d7; m_d3 = 0; m_done = 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin : refModel
    int  cur;
    int  remOld;
    bit  exp;
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_rem = 0; m_pre = 0; m_saved = 0; m_run = 0;
      m_d7 = 0; m_d6 = 0; m_d3 = 0; m_d2 = 0; m_done = 0; m_abort = 0; m_rej = 0;
    end else begin
      cur    = m_mode;
      remOld = m_rem;
      exp    = m_run && (m_pre == TDIV - 1) && (m_rem == 1);
      m_done = 0; m_abort = 0; m_rej = 0;
      if (m_run) begin
        if (m_pre == TDIV - 1) begin
          m_pre = 0; m_rem = m_rem - 1;
          if (m_rem == 0) m_run = 0;
        end else m_pre = m_pre + 1;
      end
      if (statusRd) begin
        if (cur == 1) m_d6 = !m_d6;
        else if (cur == 2 || cur == 3 || cur == 4) begin m_d6 = !m_d6; m_d2 = !m_d2; end
        else if (cur == 5 && hitErasing) m_d2 = !m_d2;
      end
      case (cur)
        0: begin
          if (programReq) begin m_mode = 1; startTimer(PTK); m_d7 = !progMsb; end
          else if (sectorEraseReq) begin m_mode = 2; startTimer(WIN); m_cnt = 1; m_d7 = 0; end
          else if (chipEraseReq) begin m_mode = 4; startTimer(1 << CEXP); m_d7 = 0; end
        end
        2: begin
          if (sectorEraseReq) begin
            startTimer(WIN); m_d7 = 0;
            if (m_cnt < MAXS) m_cnt = m_cnt + 1;
          end else if (suspendReq) begin
            m_mode = 5; m_run = 0; m_saved = m_cnt * (1 << BEXP); m_d3 = 0;
          end else if (programReq || chipEraseReq || resumeReq || otherWriteReq) begin
            m_mode = 0; m_run = 0; m_cnt = 0; m_abort = 1;
          end else if (exp) begin
            m_mode = 3; startTimer(m_cnt * (1 << BEXP)); m_d3 = 1;
          end
        end
        3: begin
          if (suspendReq) begin m_mode = 5; m_run = 0; m_saved = remOld; m_d3 = 0; end
          else if (exp) finishOp();
        end
        1, 4: if (exp) finishOp();
        5: begin
          if (resumeReq) begin
            m_mode = 3; startTimer(m_saved); m_saved = 0; m_d7 = 0; m_d3 = 1;
          end else if (programReq) begin
            if (hitErasing) m_rej = 1; else m_d7 = !progMsb;
          end else if (sectorEraseReq || chipEraseReq) m_rej = 1;
        end
        default: m_mode = 0;
      endcase
    end
  end

  // ---------------- comparison every cycle ----------------
  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  string curReq = "R1";

  always @(negedge clk) begin
    logic [12:0] act, expv;
    bit mBusy;
    mBusy = (m_mode >= 1 && m_mode <= 4);
    act  = {busy, suspended, statusByte, donePulse, abortPulse, rejectPulse};
    expv = {mBusy, (m_mode == 5), m_d7, m_d6, 2'b00, m_d3, m_d2, 2'b00, m_done, m_abort, m_rej};
    vectors++;
    if (act !== expv) begin
      misses++;
      $display("FAIL %s at cycle %0d: {busy,susp,status,done,abort,rej} act=%h exp=%h",
               curReq, cycles, act, expv);
    end
  end

  task automatic reportSummary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      misses++;
      $display("FAIL watchdog: act=running exp=finished");
      reportSummary();
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  // codes: 0 program, 1 sector erase, 2 chip erase, 3 suspend, 4 resume, 5 other write, 6 status read
  task automatic issueNow(int which, bit msb, bit hit);
    progMsb = msb; hitErasing = hit;
    case (which)
      0: programReq = 1;
      1: sectorEraseReq = 1;
      2: chipEraseReq = 1;
      3: suspendReq = 1;
      4: resumeReq = 1;
      5: otherWriteReq = 1;
      default: statusRd = 1;
    endcase
    @(negedge clk);
    programReq = 0; sectorEraseReq = 0; chipEraseReq = 0; suspendReq = 0;
    resumeReq = 0; otherWriteReq = 0; statusRd = 0; hitErasing = 0; progMsb = 0;
  endtask

  task automatic issue(int which, bit msb, bit hit);
    @(negedge clk);
    issueNow(which, msb, hit);
  endtask

  task automatic idleCycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 5000 && m_mode != 0; i++) @(negedge clk);
    idleCycles(2);
  endtask

  task automatic waitLastTick();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (m_run && m_pre == TDIV - 1 && m_rem == 1) break;
    end
  endtask

  task automatic expectBit(string tag, bit actual, bit expected);
    vectors++;
    if (actual !== expected) begin
      misses++;
      $display("FAIL %s: act=%0b exp=%0b", tag, actual, expected);
    end
  endtask

  initial begin
    idleCycles(3);
    curReq = "R1";
    expectBit("R1 status zero", statusByte == 8'h00, 1'b1);
    expectBit("R1 busy low", busy, 1'b0);
    rst_n = 1'b1;
    idleCycles(2);
    issue(6, 0, 0);                           // R3: read in idle changes nothing

    curReq = "R2";
    issue(0, 1, 0);
    expectBit("R2 DQ7 inverted msb", statusByte[7], 1'b0);
    curReq = "R3";
    issue(6, 0, 0);
    issue(6, 0, 0);
    waitIdle();
    curReq = "R2";
    issue(0, 0, 0);
    waitIdle();
    expectBit("R13 DQ7 toggled after program", statusByte[7], 1'b0);

    curReq = "R4";
    issue(1, 0, 0);
    issue(6, 0, 0);
    idleCycles(3);
    issue(1, 0, 0);
    curReq = "R5";
    waitLastTick();
    idleCycles(2);
    expectBit("R5 DQ3 set after window", statusByte[3], 1'b1);
    curReq = "R3";
    issue(6, 0, 0);
    curReq = "R13";
    waitIdle();

    curReq = "R4";                            // saturation at MAX_SECTORS
    for (int k = 0; k < 5; k++) issue(1, 0, 0);
    curReq = "R5";
    waitIdle();

    curReq = "R13";                           // request on the expiry edge wins
    issue(1, 0, 0);
    waitLastTick();
    issueNow(1, 0, 0);
    waitLastTick();
    issueNow(6, 0, 0);
    waitIdle();

    curReq = "R7";
    issue(1, 0, 0);
    issue(5, 0, 0);
    idleCycles(2);
    issue(1, 0, 0);
    issue(0, 1, 0);
    idleCycles(2);
    issue(1, 0, 0);
    issue(4, 0, 0);
    waitIdle();

    curReq = "R8";
    issue(1, 0, 0);
    waitLastTick();
    idleCycles(2);
    issue(5, 0, 0);
    issue(1, 0, 0);
    issue(2, 0, 0);
    issue(0, 1, 0);
    issue(4, 0, 0);
    waitIdle();

    curReq = "R6";
    issue(2, 0, 0);
    issue(1, 0, 0);
    issue(5, 0, 0);
    issue(3, 0, 0);
    issue(6, 0, 0);
    waitIdle();

    curReq = "R9";                            // suspend inside the window
    issue(1, 0, 0);
    issue(1, 0, 0);
    issue(3, 0, 0);
    expectBit("R9 suspended flag", suspended, 1'b1);
    curReq = "R10";
    issue(6, 0, 1);
    issue(6, 0, 0);
    curReq = "R11";
    issue(0, 1, 1);
    issue(0, 0, 0);
    expectBit("R11 program outside erasing sector", statusByte[7], 1'b1);
    issue(1, 0, 0);
    issue(2, 0, 0);
    idleCycles(4);
    curReq = "R12";
    issue(4, 0, 0);
    waitIdle();

    curReq = "R9";                            // suspend while erasing
    issue(1, 0, 0);
    waitLastTick();
    idleCycles(5);
    issue(3, 0, 0);
    idleCycles(3);
    curReq = "R12";
    issue(4, 0, 0);
    curReq = "R9";                            // suspend on the last tick
    waitLastTick();
    issueNow(3, 0, 0);
    idleCycles(2);
    curReq = "R12";
    issue(4, 0, 0);
    waitIdle();
    expectBit("R12 idle after resumed erase", busy, 1'b0);

    idleCycles(3);
    reportSummary();
    $finish;
  end

endmodule